// File: doc/BRIEF.md
# Key Zero-Bit-Count Integrity Checker

This block verifies stored 256-bit keys by counting their zero bits. A key check begins with a one-cycle `start` pulse. The pulse carries the key slot number and the zero count recorded for that key when the device was provisioned. The key then arrives as eight 32-bit words on a valid/ready stream. After the eighth word, the block pulses `done` and holds the result. The result is the total zero count, a flag saying whether the count differs from the recorded one, and a flag for a key that reads as all zeros. An all-zero key has 256 zeros and counts as never programmed. Software replaces such a key with the filler pattern offered on `fill_word`.

Every mismatch sets one bit of the `key_err` vector, indexed by slot. That bit stays set until reset. Firmware reads the vector before it allows the secured life-cycle state: any set bit there is an invalid-key condition. The block also builds the provisioning configuration word. Bits [7:0] of that word hold the last count and bits [23:8] hold a 16-bit general-purpose value.

Stream rules are as follows. `w_ready` is high exactly while a check is in progress and is low when idle. A word is taken only in a cycle with `w_valid` and `w_ready` both high. The source may drop `w_valid` at any time to stall, and the block never back-pressures a running check. `start` is honoured only while idle.

Top module: `kzc_checker`

## Requirements
- R1: After reset `busy`, `w_ready`, `done`, `mismatch`, `blank` and `key_err` are 0 and `zcount` is 0.
- R2: A `start` pulse while idle makes `busy` and `w_ready` go high on the next cycle. `start` while busy is ignored: the slot and recorded count of the running check are kept.
- R3: Each accepted word (`w_valid` and `w_ready` both high) adds its number of 0 bits to the running count. Cycles with `w_valid` low add nothing and do not advance the word index.
- R4: The cycle after the eighth accepted word, `done` is high for exactly one cycle and `busy` and `w_ready` are low. `zcount` then holds the 9-bit total and keeps it until the next check completes.
- R5: `mismatch` shows whether the total differs from the recorded count given with `start`. A mismatch sets `key_err[slot]` in the same cycle that `done` rises.
- R6: `blank` is 1 exactly when the held total is 256. `fill_word` repeats the bytes 01, 02, 03, 04, with byte 01 in bits [7:0].
- R7: `cfg_word` is the low 8 bits of `zcount` in bits [7:0], `gp_val` in bits [23:8], and 0 in bits [31:24].
- R8: A set `key_err` bit clears only on reset. A later matching check of the same slot leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a key check (honoured when idle) |
| key_sel | input | 2 | Key slot of the check |
| ref_cnt | input | 9 | Zero count recorded at provisioning |
| gp_val | input | 16 | General-purpose value for the configuration word |
| w_valid | input | 1 | Key word valid |
| w_ready | output | 1 | Block accepts key words |
| w_data | input | 32 | Key word |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| zcount | output | 9 | Zero count of the last completed check |
| mismatch | output | 1 | Last count differed from recorded count |
| blank | output | 1 | Last key was all zeros |
| cfg_word | output | 32 | Packed configuration word |
| fill_word | output | 32 | Filler pattern for blank keys |
| key_err | output | 4 | Sticky per-slot key error |

## Verification
A wrong word index or a lost stall shows up as `done` rising a cycle early or late. It also shows as `w_ready` staying high or dropping at the wrong time, which is visible within one cycle of the eighth beat. A corrupted accumulator appears in `zcount`, `cfg_word`, `blank` and `mismatch` on the cycle `done` rises. A corrupted slot register shows up as the wrong `key_err` bit in that same cycle. The bench therefore compares every output against a behavioural model on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/kzc_pkg.sv
package kzc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} kzc_state_e;

  // Filler byte for byte lane b: cycles 1,2,3,4
  function automatic logic [7:0] fill_byte(input int b);
    return 8'((b % 4) + 1);
  endfunction
endpackage

// File: rtl/kzc_zero_count.sv
module kzc_zero_count #(
  parameter int WORD_W = 32,
  localparam int ZW = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  output logic [ZW-1:0]     zeros
);
  always_comb begin
    zeros = '0;
    for (int i = 0; i < WORD_W; i++) begin
      zeros = zeros + ZW'(!word[i]);
    end
  end
endmodule

// File: rtl/kzc_accum.sv
module kzc_accum
  import kzc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int KEY_WORDS = 8,
  localparam int ZW     = $clog2(WORD_W + 1),
  localparam int CNT_W  = $clog2(WORD_W * KEY_WORDS + 1),
  localparam int WIDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] ref_cnt,
  input  logic             w_valid,
  input  logic [ZW-1:0]    wzeros,
  output logic             take,
  output logic             busy,
  output logic             done,
  output logic             set_err,
  output logic [CNT_W-1:0] total,
  output logic             mismatch
);
  kzc_state_e       state_q;
  logic [WIDX_W-1:0] widx_q;
  logic [CNT_W-1:0] acc_q, ref_q, sum_next;
  logic             beat, last;

  assign busy     = (state_q == ST_RUN);
  assign take     = start && !busy;
  assign beat     = busy && w_valid;
  assign last     = beat && (widx_q == WIDX_W'(KEY_WORDS - 1));
  assign sum_next = acc_q + CNT_W'(wzeros);
  assign set_err  = last && (sum_next != ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      widx_q   <= '0;
      acc_q    <= '0;
      ref_q    <= '0;
      total    <= '0;
      mismatch <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        state_q <= ST_RUN;
        widx_q  <= '0;
        acc_q   <= '0;
        ref_q   <= ref_cnt;
      end else if (beat) begin
        acc_q  <= sum_next;
        widx_q <= widx_q + 1'b1;
        if (last) begin
          state_q  <= ST_IDLE;
          total    <= sum_next;
          mismatch <= (sum_next != ref_q);
          done     <= 1'b1;
        end
      end
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(acc_q) <= 32'(widx_q) * WORD_W));  // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4
  AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(total));  // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R4
endmodule

// File: rtl/kzc_err_vec.sv
module kzc_err_vec #(
  parameter int NUM_KEYS = 4,
  localparam int KSEL_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set,
  input  logic [KSEL_W-1:0]   idx,
  output logic [NUM_KEYS-1:0] err
);
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          err[k] <= 1'b0;
      else if (set && idx == KSEL_W'(k))   err[k] <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err) & ~err) == '0));  // R8
endmodule

// File: rtl/kzc_checker.sv
module kzc_checker #(
  parameter int NUM_KEYS  = 4,
  parameter int WORD_W    = 32,
  parameter int KEY_WORDS = 8,
  parameter int GP_W      = 16,
  parameter int CFG_W     = 32,
  localparam int CNT_W  = $clog2(WORD_W * KEY_WORDS + 1),
  localparam int ZW     = $clog2(WORD_W + 1),
  localparam int KSEL_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
  localparam int NBYTES = WORD_W / 8,
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W * KEY_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [KSEL_W-1:0]   key_sel,
  input  logic [CNT_W-1:0]    ref_cnt,
  input  logic [GP_W-1:0]     gp_val,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic [WORD_W-1:0]   w_data,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-1:0]    zcount,
  output logic                mismatch,
  output logic                blank,
  output logic [CFG_W-1:0]    cfg_word,
  output logic [WORD_W-1:0]   fill_word,
  output logic [NUM_KEYS-1:0] key_err
);
  logic [ZW-1:0]     wzeros;
  logic              take, set_err;
  logic [KSEL_W-1:0] sel_q;

  kzc_zero_count #(.WORD_W(WORD_W)) u_zc (.word(w_data), .zeros(wzeros));

  kzc_accum #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_cnt(ref_cnt),
    .w_valid(w_valid), .wzeros(wzeros), .take(take), .busy(busy),
    .done(done), .set_err(set_err), .total(zcount), .mismatch(mismatch));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (take) sel_q <= key_sel;
  end

  kzc_err_vec #(.NUM_KEYS(NUM_KEYS)) u_err (
    .clk(clk), .rst_n(rst_n), .set(set_err), .idx(sel_q), .err(key_err));

  assign w_ready  = busy;
  assign blank    = (zcount == FULL);
  assign cfg_word = CFG_W'({gp_val, zcount[7:0]});

  for (genvar b = 0; b < NBYTES; b++) begin : g_fill
    assign fill_word[8*b +: 8] = kzc_pkg::fill_byte(b);
  end

  AST_ERR_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mismatch) |-> key_err[sel_q]);  // R5
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q));  // R2
endmodule

// File: tb/tb_kzc_checker.sv
`timescale 1ns/1ps
module tb_kzc_checker;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, w_valid = 0;
  logic [1:0]  key_sel = 0;
  logic [8:0]  ref_cnt = 0;
  logic [15:0] gp_val = 16'hA55A;
  logic [31:0] w_data = 0;
  logic        w_ready, busy, done, mismatch, blank;
  logic [8:0]  zcount;
  logic [31:0] cfg_word, fill_word;
  logic [3:0]  key_err;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  kzc_checker dut (.*);

  // behavioural model
  int m_busy = 0, m_beats = 0, m_acc = 0, m_ref = 0, m_sel = 0;
  int m_z = 0, m_done = 0, m_mis = 0;
  bit [3:0] m_err = 0;

  function automatic int zeros32(input logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) if (w[i] == 1'b0) n++;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_beats = 0; m_acc = 0; m_ref = 0; m_sel = 0;
      m_z = 0; m_done = 0; m_mis = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; m_sel = key_sel; m_ref = ref_cnt; m_acc = 0; m_beats = 0;
        end
      end else if (w_valid) begin
        m_acc += zeros32(w_data);
        m_beats++;
        if (m_beats == 8) begin
          m_busy = 0; m_done = 1; m_z = m_acc; m_mis = (m_z != m_ref);
          if (m_mis != 0) m_err[m_sel] = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", busy, m_busy);
      chk("R2 w_ready", w_ready, m_busy);
      chk("R4 done", done, m_done);
      chk("R3 zcount", zcount, m_z);
      chk("R5 mismatch", mismatch, m_mis);
      chk("R6 blank", blank, m_z == 256);
      chk("R7 cfg_word", cfg_word, {8'h00, gp_val, 8'(m_z)});
      chk("R8 key_err", key_err, m_err);
    end
  end

  function automatic logic [31:0] pat(input int kind, input int i);
    case (kind)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0403_0201;
      default: return (32'h8000_0001 << i) ^ 32'h00F0_0F00;
    endcase
  endfunction

  function automatic int key_zeros(input int kind);
    int n = 0;
    for (int i = 0; i < 8; i++) n += zeros32(pat(kind, i));
    return n;
  endfunction

  task automatic run_key(input int sel, input int rc, input int kind,
                         input bit stall, input bit poke);
    @(posedge clk); #1;
    start = 1; key_sel = 2'(sel); ref_cnt = 9'(rc);
    @(posedge clk); #1;
    start = 0;
    for (int i = 0; i < 8; i++) begin
      if (stall && (i % 3 == 1)) begin
        w_valid = 0; w_data = 32'hDEAD_BEEF;
        @(posedge clk); #1;
      end
      if (poke && i == 3) begin start = 1; key_sel = 2'(sel + 1); ref_cnt = 9'd0; end
      w_valid = 1; w_data = pat(kind, i);
      @(posedge clk); #1;
      start = 0;
    end
    w_valid = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 key_err", key_err, 0); chk("R1 zcount", zcount, 0);
    chk("R1 w_ready", w_ready, 0);
    rst_n = 1;
    chk("R6 fill_word", fill_word, 32'h0403_0201);
    run_key(0, 256, 0, 0, 0);                  // blank key, matching
    chk("R6 blank after zero key", blank, 1);
    run_key(1, 0, 1, 1, 0);                    // all ones, stalls
    gp_val = 16'h1234;
    run_key(2, key_zeros(2), 2, 1, 0);         // filler pattern
    chk("R7 cfg low byte", cfg_word[7:0], 216);
    run_key(3, 200, 2, 0, 0);                  // mismatch
    chk("R5 slot3 err", key_err[3], 1);
    run_key(1, 5, 0, 0, 1);                    // mismatch, start while busy
    chk("R2 poke ignored slot2 clean", key_err[2], 0);
    chk("R5 slot1 err", key_err[1], 1);
    run_key(3, key_zeros(3), 3, 1, 0);         // matching, err stays
    chk("R8 slot3 still set", key_err[3], 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule